// File: doc/BRIEF.md
# Integer Register File with Hardwired Zero Entry

This block is the general-purpose register file of a 32-bit or 64-bit load/store integer core. It holds a parameterised number of registers (32 by default), each `XLEN` bits wide, and serves one instruction per cycle. The instruction's two source operands are read through two independent combinational read ports, and its result is written through one write port on the rising clock edge. The program counter is kept elsewhere and cannot be reached through this file.

Entry 0 is not a storage element. It returns zero on every read port, and any write aimed at it is dropped. All other entries can be read and written freely. A synchronous reset clears every entry. A read port whose index matches the index being written in the same cycle returns the incoming data (write-first), so a core without forwarding sees the newest value. A third read port shows the stored contents of any entry for debug inspection. It has no bypass, and it can be removed by a parameter.

Top module: `int_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every entry is cleared to zero. Once reset is released, every index reads zero on all read ports until a write is made.
- R2: Index 0 reads as zero on both operand ports and on the debug port, including in the cycle of a write to index 0 and after it. A write to index 0 changes no entry.
- R3: When `wr_en` is 1 and `wr_idx` is not 0 at a rising edge (with `rst` low), entry `wr_idx` takes `wr_data`. From the next cycle on, every read port returns that value for that index.
- R4: When `wr_en` is 0 at a rising edge, no entry changes, whatever `wr_idx` and `wr_data` carry.
- R5: The two operand ports are combinational and independent. In the same cycle, `op_a_data` returns entry `op_a_idx` and `op_b_data` returns entry `op_b_idx`, with no clock cycle of latency.
- R6: With `WRITE_FIRST`=1, when `wr_en` is 1, `rst` is 0, `wr_idx` is not 0 and an operand index equals `wr_idx`, that operand port returns `wr_data` in the same cycle, before the edge.
- R7: With `DEBUG_EN`=1, `dbg_data` returns the stored contents of entry `dbg_idx` combinationally. It has no write-first bypass and reads zero for index 0.
- R8: A write changes only the addressed entry. Every other entry keeps its value.
- R9: When `rst` and `wr_en` are both high at the same edge, the reset wins and the written entry reads zero afterwards. No bypass occurs while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the result port |
| wr_idx | input | IDX_W (5) | Destination entry index |
| wr_data | input | XLEN (32) | Result data to store |
| op_a_idx | input | IDX_W (5) | First source operand index |
| op_a_data | output | XLEN (32) | First source operand value |
| op_b_idx | input | IDX_W (5) | Second source operand index |
| op_b_data | output | XLEN (32) | Second source operand value |
| dbg_idx | input | IDX_W (5) | Debug inspection index |
| dbg_data | output | XLEN (32) | Stored contents of the entry at `dbg_idx` |

## Verification
The operand and debug outputs are combinational. The bench drives inputs just after the falling edge and compares the outputs one time step later in the same cycle, before the next rising edge. A bypassed value is therefore expected in the cycle of the write, and a stored value from the cycle after the edge that wrote it. The reference array is updated only after the rising edge has passed, so each comparison sees exactly the writes that the hardware has already committed. Reset and write collisions are checked in the first cycle after reset is released.

// File: rtl/rf_pkg.sv
package rf_pkg;

   localparam int unsigned RF_DEF_XLEN = 32;
   localparam int unsigned RF_DEF_NREG = 32;

   typedef enum logic [0:0] {
      RD_STORED      = 1'b0,
      RD_WRITE_FIRST = 1'b1
   } rd_mode_e;

   function automatic bit rf_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int unsigned NREG  = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   output logic [NREG-1:0]  we_vec
);

   always_comb begin
      we_vec = '0;
      for (int unsigned i = 1; i < NREG; i++) begin
         if (!rst && wr_en && (wr_idx == IDX_W'(i))) begin
            we_vec[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NREG = 32
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NREG-1:0]           we_vec,
   input  logic [XLEN-1:0]           wr_data,
   output logic [NREG-1:0][XLEN-1:0] regs_q
);

   for (genvar i = 0; i < NREG; i++) begin : g_entry
      if (i == 0) begin : g_zero
         assign regs_q[i] = '0;
      end else begin : g_store
         always_ff @(posedge clk) begin
            if (rst) begin
               regs_q[i] <= '0;
            end else if (we_vec[i]) begin
               regs_q[i] <= wr_data;
            end
         end

         // R1: the first cycle after reset finds the entry cleared
         p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (regs_q[i] == '0));

         // R4 / R8: an entry not selected for writing keeps its value
         p_hold_unselected_r4: assert property (@(posedge clk) disable iff (rst)
            !we_vec[i] |=> $stable(regs_q[i]));
      end
   end

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
   parameter int unsigned      XLEN  = 32,
   parameter int unsigned      NREG  = 32,
   parameter int unsigned      IDX_W = 5,
   parameter rf_pkg::rd_mode_e MODE  = rf_pkg::RD_WRITE_FIRST
) (
   input  logic [NREG-1:0][XLEN-1:0] regs_q,
   input  logic [IDX_W-1:0]          idx,
   input  logic                      byp_en,
   input  logic [IDX_W-1:0]          byp_idx,
   input  logic [XLEN-1:0]           byp_data,
   output logic [XLEN-1:0]           data
);

   logic [XLEN-1:0] stored;

   assign stored = regs_q[idx];

   if (MODE == rf_pkg::RD_WRITE_FIRST) begin : g_write_first
      logic hit;
      assign hit  = byp_en && (byp_idx == idx) && (idx != '0);
      assign data = hit ? byp_data : stored;
   end else begin : g_stored
      logic [IDX_W-1:0] unused_idx;
      logic [XLEN-1:0]  unused_data;
      logic             unused_en;
      assign unused_idx  = byp_idx;
      assign unused_data = byp_data;
      assign unused_en   = byp_en;
      assign data        = stored;
   end

endmodule

// File: rtl/int_regfile.sv
module int_regfile #(
   parameter int unsigned XLEN        = rf_pkg::RF_DEF_XLEN,
   parameter int unsigned NREG        = rf_pkg::RF_DEF_NREG,
   parameter bit          WRITE_FIRST = 1'b1,
   parameter bit          DEBUG_EN    = 1'b1,
   localparam int unsigned IDX_W      = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]  wr_data,
   input  logic [IDX_W-1:0] op_a_idx,
   output logic [XLEN-1:0]  op_a_data,
   input  logic [IDX_W-1:0] op_b_idx,
   output logic [XLEN-1:0]  op_b_data,
   input  logic [IDX_W-1:0] dbg_idx,
   output logic [XLEN-1:0]  dbg_data
);

   localparam int unsigned NPORT = 2;
   localparam rf_pkg::rd_mode_e OP_MODE =
      WRITE_FIRST ? rf_pkg::RD_WRITE_FIRST : rf_pkg::RD_STORED;

   if (XLEN < 8) begin : g_bad_xlen
      $error("int_regfile: XLEN must be at least 8");
   end
   if (!rf_pkg::rf_is_pow2(NREG) || NREG < 2) begin : g_bad_nreg
      $error("int_regfile: NREG must be a power of two, at least 2");
   end

   logic [NREG-1:0]           we_vec;
   logic [NREG-1:0][XLEN-1:0] regs_q;
   logic                      byp_en;
   logic [IDX_W-1:0]          port_idx  [NPORT];
   logic [XLEN-1:0]           port_data [NPORT];

   assign byp_en      = wr_en && !rst;
   assign port_idx[0] = op_a_idx;
   assign port_idx[1] = op_b_idx;
   assign op_a_data   = port_data[0];
   assign op_b_data   = port_data[1];

   rf_wr_decode #(
      .NREG  (NREG),
      .IDX_W (IDX_W)
   ) i_decode (
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .we_vec (we_vec)
   );

   rf_bank #(
      .XLEN (XLEN),
      .NREG (NREG)
   ) i_bank (
      .clk     (clk),
      .rst     (rst),
      .we_vec  (we_vec),
      .wr_data (wr_data),
      .regs_q  (regs_q)
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_op_port
      rf_rd_port #(
         .XLEN  (XLEN),
         .NREG  (NREG),
         .IDX_W (IDX_W),
         .MODE  (OP_MODE)
      ) i_port (
         .regs_q   (regs_q),
         .idx      (port_idx[p]),
         .byp_en   (byp_en),
         .byp_idx  (wr_idx),
         .byp_data (wr_data),
         .data     (port_data[p])
      );
   end

   if (DEBUG_EN) begin : g_dbg
      rf_rd_port #(
         .XLEN  (XLEN),
         .NREG  (NREG),
         .IDX_W (IDX_W),
         .MODE  (rf_pkg::RD_STORED)
      ) i_dbg_port (
         .regs_q   (regs_q),
         .idx      (dbg_idx),
         .byp_en   (1'b0),
         .byp_idx  ('0),
         .byp_data ('0),
         .data     (dbg_data)
      );
   end else begin : g_no_dbg
      logic [IDX_W-1:0] unused_dbg_idx;
      assign unused_dbg_idx = dbg_idx;
      assign dbg_data       = '0;
   end

   // R2: index 0 is zero on both operand ports
   p_zero_op_a_r2: assert property (@(posedge clk) disable iff (rst)
      (op_a_idx == '0) |-> (op_a_data == '0));
   p_zero_op_b_r2: assert property (@(posedge clk) disable iff (rst)
      (op_b_idx == '0) |-> (op_b_data == '0));

   // R7: the debug port also reads zero at index 0
   p_zero_dbg_r7: assert property (@(posedge clk) disable iff (rst)
      (dbg_idx == '0) |-> (dbg_data == '0));

   // R3: a write to a nonzero index lands in that entry
   p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_idx != '0)) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

   // R6: write-first bypass on both operand ports
   p_bypass_a_r6: assert property (@(posedge clk) disable iff (rst)
      (WRITE_FIRST && wr_en && (wr_idx != '0) && (wr_idx == op_a_idx))
         |-> (op_a_data == wr_data));
   p_bypass_b_r6: assert property (@(posedge clk) disable iff (rst)
      (WRITE_FIRST && wr_en && (wr_idx != '0) && (wr_idx == op_b_idx))
         |-> (op_b_data == wr_data));

endmodule

// File: tb/test_int_regfile.sv
module test_int_regfile;

   localparam int unsigned XLEN  = 32;
   localparam int unsigned NREG  = 32;
   localparam int unsigned IDX_W = 5;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             wr_en = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic [XLEN-1:0]  wr_data = '0;
   logic [IDX_W-1:0] op_a_idx = '0;
   logic [IDX_W-1:0] op_b_idx = '0;
   logic [IDX_W-1:0] dbg_idx = '0;
   logic [XLEN-1:0]  op_a_data;
   logic [XLEN-1:0]  op_b_data;
   logic [XLEN-1:0]  dbg_data;

   logic [XLEN-1:0] model [NREG];
   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   int_regfile i_int_regfile (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .op_a_idx  (op_a_idx),
      .op_a_data (op_a_data),
      .op_b_idx  (op_b_idx),
      .op_b_data (op_b_data),
      .dbg_idx   (dbg_idx),
      .dbg_data  (dbg_data)
   );

   task automatic chk(input string req, input logic [XLEN-1:0] act,
                      input logic [XLEN-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [XLEN-1:0] exp_op(input logic [IDX_W-1:0] idx);
      if (idx == 0) return '0;
      if (!rst && wr_en && wr_idx == idx) return wr_data;
      return model[idx];
   endfunction

   function automatic logic [XLEN-1:0] exp_dbg(input logic [IDX_W-1:0] idx);
      return (idx == 0) ? '0 : model[idx];
   endfunction

   function automatic string tag_op(input logic [IDX_W-1:0] idx);
      if (idx == 0) return "R2";
      if (wr_en && wr_idx == idx) return "R6";
      return "R5";
   endfunction

   task automatic commit();
      @(posedge clk);
      if (rst) begin
         for (int i = 0; i < NREG; i++) model[i] = '0;
      end else if (wr_en && wr_idx != 0) begin
         model[wr_idx] = wr_data;
      end
   endtask

   task automatic drive(input logic we, input logic [IDX_W-1:0] wi,
                        input logic [XLEN-1:0] wd, input logic [IDX_W-1:0] ai,
                        input logic [IDX_W-1:0] bi, input logic [IDX_W-1:0] di);
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_data = wd;
      op_a_idx = ai; op_b_idx = bi; dbg_idx = di;
      #1;
   endtask

   task automatic check_ports();
      chk(tag_op(op_a_idx), op_a_data, exp_op(op_a_idx));
      chk(tag_op(op_b_idx), op_b_data, exp_op(op_b_idx));
      chk("R7", dbg_data, exp_dbg(dbg_idx));
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) model[i] = '0;
      void'($urandom(32'h1c3a_5e71));
      rst = 1'b1;
      repeat (3) commit();

      // R9: write collides with reset; reset wins, no bypass
      drive(1'b1, 5'd9, 32'hdead_beef, 5'd9, 5'd9, 5'd9);
      chk("R9", op_a_data, 32'h0);
      commit();
      @(negedge clk);
      rst = 1'b0;
      wr_en = 1'b0;
      #1;

      // R1: every entry zero after reset
      for (int i = 0; i < NREG; i++) begin
         drive(1'b0, '0, '0, IDX_W'(i), IDX_W'(NREG - 1 - i), IDX_W'(i));
         chk("R1", op_a_data, 32'h0);
         chk("R1", op_b_data, 32'h0);
         chk("R1", dbg_data, 32'h0);
         commit();
      end

      // R2: write to index 0 is discarded
      drive(1'b1, 5'd0, 32'hffff_ffff, 5'd0, 5'd0, 5'd0);
      chk("R2", op_a_data, 32'h0);
      commit();
      drive(1'b0, '0, '0, 5'd0, 5'd0, 5'd0);
      chk("R2", op_b_data, 32'h0);
      chk("R2", dbg_data, 32'h0);
      commit();

      // R3 / R6 / R7: write 5, bypass in-cycle, stored next cycle
      drive(1'b1, 5'd5, 32'h1234_5678, 5'd5, 5'd6, 5'd5);
      chk("R6", op_a_data, 32'h1234_5678);
      chk("R7", dbg_data, 32'h0);
      commit();
      drive(1'b0, 5'd5, 32'hcafe_f00d, 5'd5, 5'd5, 5'd5);
      chk("R3", op_a_data, 32'h1234_5678);
      chk("R7", dbg_data, 32'h1234_5678);
      commit();

      // R4: disabled write leaves entry 5 unchanged
      drive(1'b0, '0, '0, 5'd5, 5'd0, 5'd5);
      chk("R4", op_a_data, 32'h1234_5678);
      commit();

      // R8: write 7 leaves neighbours 6 and 8 untouched
      drive(1'b1, 5'd6, 32'h0000_0066, 5'd0, 5'd0, 5'd0);
      commit();
      drive(1'b1, 5'd8, 32'h0000_0088, 5'd0, 5'd0, 5'd0);
      commit();
      drive(1'b1, 5'd7, 32'h7777_7777, 5'd0, 5'd0, 5'd0);
      commit();
      drive(1'b0, '0, '0, 5'd6, 5'd8, 5'd7);
      chk("R8", op_a_data, 32'h0000_0066);
      chk("R8", op_b_data, 32'h0000_0088);
      chk("R3", dbg_data, 32'h7777_7777);
      commit();

      // R5: both ports read different entries in the same cycle
      drive(1'b0, '0, '0, 5'd7, 5'd5, 5'd0);
      chk("R5", op_a_data, 32'h7777_7777);
      chk("R5", op_b_data, 32'h1234_5678);
      commit();

      // R5 / R6 / R2 / R7: constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [IDX_W-1:0] wi, ai, bi;
         wi = ($urandom_range(0, 7) == 0) ? '0 : IDX_W'($urandom);
         ai = ($urandom_range(0, 3) == 0) ? wi : IDX_W'($urandom);
         bi = ($urandom_range(0, 3) == 0) ? wi : IDX_W'($urandom);
         drive(($urandom_range(0, 3) != 0), wi, $urandom, ai, bi, IDX_W'($urandom));
         check_ports();
         commit();
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule